// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Folded Extended Lines

This block collects 32 interrupt request lines and distributes them to as many as sixteen processors. Lines 1 to 15 are standard requests. Lines 16 to 31 are extended requests: they never appear as a level of their own. When one of them is due for a processor, that processor sees a single, build-time selectable standard line. The identifier of the extended source is kept in a per-processor register so that software can find out which source it was.

Each processor has a 4-bit level output, an acknowledge strobe with the acknowledged level, and a run output. A word-wide register bus gives access to the following state: a shared pending set, a priority split (the level register), a write-one-to-clear port, a status word that also releases halted processors, a broadcast selector, and per-processor banks for masks, forced requests and the extended identifier. Bit 0 of every request vector is unused.

Top module: `mp_intc`

## Requirements
- R1: After reset, the status word at offset 0x10 reads (NCPU-1) in bits 31:28, EXT_LINE in bits 19:16, and ones in bits 1..NCPU-1 (halted processors), with all other bits zero. Every level output is 0 and only run bit 0 is high.
- R2: Bit 0 is unused. It reads as zero in the level (0x00), pending (0x04), force and mask registers, and a rising edge on input 0 leaves the pending set unchanged.
- R3: A rising edge on input k (1..31) sets pending bit k on the next clock edge. A write to 0x04 replaces the whole pending set.
- R4: A processor's effective set is (pending OR its own force) AND its own mask (mask bank at 0x40+4*i, force bank at 0x80+4*i). When that set is empty, its level output is 0.
- R5: Effective bits whose level-register bit is 1 form the high group; the remaining bits form the low group. The level output is the highest index in the high group, or, if the high group is empty, the highest index in the low group.
- R6: If any of bits 16..31 is in a processor's effective set, its level output equals EXT_LINE. The highest such index appears in its extended register (0xC0+4*i, bits 4:0) one clock later.
- R7: An acknowledge of a non-zero level L by processor i clears pending bit L and bit L of that processor's own force register, but not the force bits of other processors.
- R8: An acknowledge of level EXT_LINE also clears the highest extended source that is currently effective for that processor. If none is effective, it clears the source last held in that processor's extended register.
- R9: A write to 0x10 clears the halted bits that are written as 1 and raises those run outputs. The EXT_LINE and processor-count fields keep their values, and processor 0 always runs.
- R10: A write to 0x0C clears each pending bit that is written as 1. Offset 0x0C reads as zero.
- R11: A write to 0x08 loads processor 0's force register. For every other processor, it also ORs in the written bits that are set in the broadcast register at 0x14.
- R12: If a rising edge on a line occurs in the same cycle as a clear of that line (acknowledge or write to 0x0C), the pending bit is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, edge sensitive |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high with bus_en |
| bus_addr | input | 8 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_ack | input | NCPU | Per-processor acknowledge strobe |
| cpu_ack_lvl | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| cpu_lvl | output | 4*NCPU | Requested level, 4 bits per processor, 0 means none |
| cpu_run | output | NCPU | Per-processor run enable |

## Verification
The edge detector and the clearing paths can act on the same pending bit in one cycle. The bench provokes this twice. First, it raises a line in the same cycle in which processor 0 acknowledges that level. Second, it raises the line together with a write of that bit to the clear register. In both cases it reads the pending word afterwards and expects the bit to be set. A second overlap is between an extended acknowledge and a second extended source. After the first acknowledge, the bench expects the level to stay at the folded line, and it expects the extended register to move to the next source.

// File: rtl/mp_intc_pkg.sv
// Shared constants and helpers for the multiprocessor interrupt controller.
// Assumes a 256-byte register window with word-aligned accesses.
package mp_intc_pkg;
    localparam int NLINES  = 32;
    localparam int NSTD    = 16;
    localparam int LVL_W   = 4;
    localparam int IDX_W   = 5;
    localparam int MAX_CPU = 16;

    localparam logic [7:0] OFS_LEVEL  = 8'h00;
    localparam logic [7:0] OFS_PEND   = 8'h04;
    localparam logic [7:0] OFS_FORCE0 = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_BCAST  = 8'h14;

    localparam logic [1:0] BANK_MASK  = 2'b01;
    localparam logic [1:0] BANK_FORCE = 2'b10;
    localparam logic [1:0] BANK_EXT   = 2'b11;

    // Index of the highest set bit, zero when the vector is empty.
    function automatic logic [IDX_W-1:0] top_index(input logic [NLINES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < NLINES; k++) begin
            if (v[k]) r = IDX_W'(k);
        end
        return r;
    endfunction
endpackage

// File: rtl/mp_intc_edge.sv
// Rising-edge detector for a vector of request lines.
// Assumes the lines are already synchronous to clk.
module mp_intc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember last cycle's line values.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/mp_intc_cpu.sv
// Per-processor request path: effective set, extended folding, two-group
// priority, extended identifier latch and acknowledge clear mask.
// Assumes EXT_LINE lies in 1..15 (checked by the top).
module mp_intc_cpu
    import mp_intc_pkg::*;
#(
    parameter int EXT_LINE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] force_v,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] level,
    input  logic              ack,
    input  logic [LVL_W-1:0]  ack_lvl,
    output logic [LVL_W-1:0]  lvl,
    output logic [NLINES-1:0] ack_clr,
    output logic [IDX_W-1:0]  ext_id
);
    localparam logic [NLINES-1:0] EXT_FIELD = {{(NLINES-NSTD){1'b1}}, {NSTD{1'b0}}};

    logic [NLINES-1:0] eff, folded, hi_grp, lo_grp;
    logic              ext_any;
    logic [IDX_W-1:0]  ext_now, ext_sel, ext_q;

    // Effective set, folding of extended lines and priority selection.
    always_comb begin
        eff     = (pend | force_v) & mask;
        eff[0]  = 1'b0;
        ext_any = |(eff & EXT_FIELD);
        ext_now = top_index(eff & EXT_FIELD);
        folded  = ext_any ? (NLINES'(1) << EXT_LINE) : eff;
        hi_grp  = folded & level;
        lo_grp  = folded & ~level;
        lvl     = (|hi_grp) ? LVL_W'(top_index(hi_grp)) : LVL_W'(top_index(lo_grp));
    end

    // Bits to clear on an acknowledge, including the extended source.
    always_comb begin
        ext_sel = ext_any ? ext_now : ext_q;
        ack_clr = '0;
        if (ack && (ack_lvl != '0)) begin
            ack_clr = NLINES'(1) << ack_lvl;
            if (ack_lvl == LVL_W'(EXT_LINE)) ack_clr = ack_clr | (NLINES'(1) << ext_sel);
        end
        ack_clr[0] = 1'b0;
    end

    // Latch the highest extended source while one is effective.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_q <= '0;
        else if (ext_any) ext_q <= ext_now;
    end

    assign ext_id = ext_q;
endmodule

// File: rtl/mp_intc.sv
// Multiprocessor interrupt controller top: register file, bus decode,
// edge capture and one request path per processor.
// Assumes word-aligned accesses and synchronous request lines.
module mp_intc
    import mp_intc_pkg::*;
#(
    parameter int NCPU     = 2,
    parameter int EXT_LINE = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINES-1:0]     irq_in,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NCPU-1:0]       cpu_ack,
    input  logic [NCPU*LVL_W-1:0] cpu_ack_lvl,
    output logic [NCPU*LVL_W-1:0] cpu_lvl,
    output logic [NCPU-1:0]       cpu_run
);
    localparam logic [NLINES-1:0]  BIT0_OFF  = ~NLINES'(1);
    localparam logic [MAX_CPU-1:0] HALT_INIT = MAX_CPU'((32'd1 << NCPU) - 32'd2);

    if (EXT_LINE < 1 || EXT_LINE > 15) begin : g_bad_ext
        $error("EXT_LINE must be within 1..15");
    end
    if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
        $error("NCPU must be within 1..16");
    end

    logic [NLINES-1:0]             pend_r, pend_nxt, level_r, bcast_r;
    logic [NCPU-1:0][NLINES-1:0]   force_r, force_nxt, mask_r, ack_clr;
    logic [NCPU-1:0][IDX_W-1:0]    ext_id;
    logic [MAX_CPU-1:0]            halt_r;
    logic [NLINES-1:0]             rise_raw, rise, ack_all;
    logic                          wr, wr_level, wr_pend, wr_force0, wr_clear, wr_status, wr_bcast;
    logic [1:0]                    bank;
    logic [3:0]                    idx;

    mp_intc_edge #(.W(NLINES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise_raw)
    );
    assign rise = rise_raw & BIT0_OFF;

    // Decode single-register writes.
    always_comb begin
        wr        = bus_en && bus_we;
        bank      = bus_addr[7:6];
        idx       = bus_addr[5:2];
        wr_level  = wr && (bus_addr == OFS_LEVEL);
        wr_pend   = wr && (bus_addr == OFS_PEND);
        wr_force0 = wr && (bus_addr == OFS_FORCE0);
        wr_clear  = wr && (bus_addr == OFS_CLEAR);
        wr_status = wr && (bus_addr == OFS_STATUS);
        wr_bcast  = wr && (bus_addr == OFS_BCAST);
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        mp_intc_cpu #(.EXT_LINE(EXT_LINE)) u_cpu (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend    (pend_r),
            .force_v (force_r[i]),
            .mask    (mask_r[i]),
            .level   (level_r),
            .ack     (cpu_ack[i]),
            .ack_lvl (cpu_ack_lvl[i*LVL_W +: LVL_W]),
            .lvl     (cpu_lvl[i*LVL_W +: LVL_W]),
            .ack_clr (ack_clr[i]),
            .ext_id  (ext_id[i])
        );
        assign cpu_run[i] = ~halt_r[i];
    end

    // Next pending set: write, clears, then edges win.
    always_comb begin
        ack_all = '0;
        for (int i = 0; i < NCPU; i++) ack_all = ack_all | ack_clr[i];
        pend_nxt = wr_pend ? bus_wdata : pend_r;
        if (wr_clear) pend_nxt = pend_nxt & ~bus_wdata;
        pend_nxt = ((pend_nxt & ~ack_all) | rise) & BIT0_OFF;
    end

    // Next force registers: own write, broadcast, then acknowledge clear.
    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            force_nxt[i] = force_r[i];
            if (wr && bank == BANK_FORCE && idx == 4'(i)) force_nxt[i] = bus_wdata;
            if (wr_force0) begin
                if (i == 0) force_nxt[i] = bus_wdata;
                else        force_nxt[i] = force_nxt[i] | (bus_wdata & bcast_r);
            end
            force_nxt[i] = force_nxt[i] & ~ack_clr[i] & BIT0_OFF;
        end
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r  <= '0;
            level_r <= '0;
            bcast_r <= '0;
            force_r <= '0;
            mask_r  <= '0;
            halt_r  <= HALT_INIT;
        end else begin
            pend_r  <= pend_nxt;
            force_r <= force_nxt;
            if (wr_level)  level_r <= bus_wdata & BIT0_OFF;
            if (wr_bcast)  bcast_r <= bus_wdata & BIT0_OFF;
            if (wr_status) halt_r  <= halt_r & ~bus_wdata[MAX_CPU-1:0];
            for (int i = 0; i < NCPU; i++) begin
                if (wr && bank == BANK_MASK && idx == 4'(i)) mask_r[i] <= bus_wdata & BIT0_OFF;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LEVEL:  bus_rdata = level_r;
            OFS_PEND:   bus_rdata = pend_r;
            OFS_FORCE0: bus_rdata = force_r[0];
            OFS_STATUS: bus_rdata = {4'(NCPU - 1), 8'h00, 4'(EXT_LINE), halt_r};
            OFS_BCAST:  bus_rdata = bcast_r;
            default: begin
                for (int i = 0; i < NCPU; i++) begin
                    if (idx == 4'(i) && bus_addr[1:0] == 2'b00) begin
                        if (bank == BANK_MASK)  bus_rdata = mask_r[i];
                        if (bank == BANK_FORCE) bus_rdata = force_r[i];
                        if (bank == BANK_EXT)   bus_rdata = 32'(ext_id[i]);
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/mp_intc_chk.sv
// Property checker for mp_intc, attached by bind. Observes ports and the
// pending, force and mask state; checks processor 0's request path.
module mp_intc_chk
    import mp_intc_pkg::*;
#(
    parameter int NCPU     = 2,
    parameter int EXT_LINE = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NLINES-1:0]           irq_in,
    input logic                        bus_en,
    input logic                        bus_we,
    input logic [7:0]                  bus_addr,
    input logic [NCPU-1:0]             cpu_ack,
    input logic [NCPU*LVL_W-1:0]       cpu_ack_lvl,
    input logic [NCPU*LVL_W-1:0]       cpu_lvl,
    input logic [NCPU-1:0]             cpu_run,
    input logic [NLINES-1:0]           pend_r,
    input logic [NCPU-1:0][NLINES-1:0] force_r,
    input logic [NCPU-1:0][NLINES-1:0] mask_r
);
    logic [NLINES-1:0] prev_c, rise_c, eff0;
    logic [LVL_W-1:0]  lvl0, ack0_lvl, ack_q;
    logic              ack_v;

    assign lvl0     = cpu_lvl[LVL_W-1:0];
    assign ack0_lvl = cpu_ack_lvl[LVL_W-1:0];
    assign rise_c   = irq_in & ~prev_c & ~NLINES'(1);
    assign eff0     = (pend_r | force_r[0]) & mask_r[0];

    // Own copy of the previous line values and the pending acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_c <= '0;
            ack_v  <= 1'b0;
            ack_q  <= '0;
        end else begin
            prev_c <= irq_in;
            ack_q  <= ack0_lvl;
            ack_v  <= cpu_ack[0] && (ack0_lvl != '0)
                      && (((rise_c >> ack0_lvl) & NLINES'(1)) == '0)
                      && !(bus_en && bus_we && bus_addr == OFS_PEND);
        end
    end

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_r[0] == 1'b0);

    p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(rise_c) & ~pend_r) == '0));

    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_r[0] == '0) |-> (lvl0 == '0));

    p_ext_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|eff0[NLINES-1:NSTD]) |-> (lvl0 == LVL_W'(EXT_LINE)));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_v |-> (((pend_r >> ack_q) & NLINES'(1)) == '0));

    p_cpu0_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run[0] == 1'b1);
endmodule

bind mp_intc mp_intc_chk #(.NCPU(NCPU), .EXT_LINE(EXT_LINE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .cpu_ack     (cpu_ack),
    .cpu_ack_lvl (cpu_ack_lvl),
    .cpu_lvl     (cpu_lvl),
    .cpu_run     (cpu_run),
    .pend_r      (pend_r),
    .force_r     (force_r),
    .mask_r      (mask_r)
);

// File: tb/mp_intc_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks push expected observations, a monitor
// pops and compares them at the falling edge.
module mp_intc_tb;
    localparam int NCPU = 2;
    localparam int EXT  = 12;
    localparam real HALF = 2.5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       irq_in = '0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   cpu_ack = '0;
    logic [NCPU*4-1:0] cpu_ack_lvl = '0;
    logic [NCPU*4-1:0] cpu_lvl;
    logic [NCPU-1:0]   cpu_run;

    typedef struct {
        int          kind;   // 0 read data, 1 level of cpu sel, 2 run vector
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    mp_intc #(.NCPU(NCPU), .EXT_LINE(EXT)) u_dut (.*);

    always #(HALF) clk = ~clk;

    // Monitor: pop every queued expectation and compare at the falling edge.
    initial forever begin
        @(negedge clk);
        while (sb_q.size() != 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = 32'(cpu_lvl[it.sel*4 +: 4]);
                default: act = 32'(cpu_run);
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick(); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick(); bus_en = 0; bus_we = 0;
    endtask
    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = 0; it.sel = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it); tick();
    endtask
    task automatic chk_lvl(input int c, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = 1; it.sel = c; it.exp = e; it.tag = tag;
        sb_q.push_back(it); tick();
    endtask
    task automatic chk_run(input logic [31:0] e, input string tag);
        item_t it;
        it.kind = 2; it.sel = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it); tick();
    endtask
    task automatic pulse(input logic [31:0] lines);
        irq_in = irq_in | lines; tick();
        irq_in = irq_in & ~lines; tick();
    endtask
    task automatic ack(input int c, input logic [3:0] l);
        cpu_ack[c] = 1'b1; cpu_ack_lvl[c*4 +: 4] = l; tick();
        cpu_ack = '0; cpu_ack_lvl = '0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk_rd(8'h10, 32'h100C_0002, "R1 status after reset");
        chk_lvl(0, 0, "R1 cpu0 level after reset");
        chk_lvl(1, 0, "R1 cpu1 level after reset");
        chk_run(32'h1, "R1 run after reset");

        wr(8'h40, 32'hFFFF_FFFF);
        chk_rd(8'h40, 32'hFFFF_FFFE, "R2 mask bit0 reads zero");
        pulse(32'h20);
        chk_lvl(0, 5, "R3 edge on line 5");
        chk_lvl(1, 0, "R4 cpu1 fully masked");
        pulse(32'h1);
        chk_rd(8'h04, 32'h20, "R2 line 0 ignored");

        pulse(32'h200);
        chk_lvl(0, 9, "R5 highest in low group");
        wr(8'h00, 32'h21);
        chk_rd(8'h00, 32'h20, "R2 level bit0 reads zero");
        chk_lvl(0, 5, "R5 high group wins");

        ack(0, 5);
        chk_rd(8'h04, 32'h200, "R7 ack clears pending bit");
        chk_lvl(0, 9, "R7 next level after ack");
        wr(8'h0C, 32'h200);
        chk_rd(8'h04, 32'h0, "R10 clear register");
        chk_rd(8'h0C, 32'h0, "R10 clear reads zero");
        chk_lvl(0, 0, "R4 empty set gives zero");

        wr(8'h44, 32'h8);
        wr(8'h84, 32'h8);
        chk_lvl(1, 3, "R4 own force seen");
        chk_lvl(0, 0, "R4 other cpu force not seen");
        ack(1, 3);
        chk_rd(8'h84, 32'h0, "R7 ack clears own force");

        pulse(32'h0012_0000);
        chk_lvl(0, EXT, "R6 extended folded");
        chk_rd(8'hC0, 32'd20, "R6 highest extended id");
        chk_lvl(1, 0, "R6 cpu1 masked");
        ack(0, 4'(EXT));
        chk_rd(8'h04, 32'h0002_0000, "R8 extended ack clears source");
        chk_lvl(0, EXT, "R8 remaining extended");
        chk_rd(8'hC0, 32'd17, "R8 next extended id");
        ack(0, 4'(EXT));
        chk_rd(8'h04, 32'h0, "R8 second extended ack");
        chk_lvl(0, 0, "R8 nothing left");

        wr(8'h10, 32'h2);
        chk_run(32'h3, "R9 start cpu1");
        chk_rd(8'h10, 32'h100C_0000, "R9 status fields kept");

        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h14, 32'h80);
        wr(8'h08, 32'h90);
        chk_rd(8'h08, 32'h90, "R11 cpu0 force loaded");
        chk_rd(8'h84, 32'h80, "R11 broadcast bit to cpu1");
        chk_lvl(1, 7, "R11 cpu1 level");
        chk_lvl(0, 7, "R11 cpu0 level");
        ack(1, 7);
        chk_rd(8'h84, 32'h0, "R7 cpu1 force cleared");
        chk_rd(8'h08, 32'h90, "R7 cpu0 force untouched");
        wr(8'h08, 32'h0);
        chk_lvl(0, 0, "R11 cpu0 force emptied");

        pulse(32'h40);
        irq_in[6] = 1'b1; cpu_ack[0] = 1'b1; cpu_ack_lvl[3:0] = 4'd6; tick();
        cpu_ack = '0; cpu_ack_lvl = '0; irq_in[6] = 1'b0; tick();
        chk_rd(8'h04, 32'h40, "R12 edge beats ack");
        irq_in[6] = 1'b1; bus_en = 1; bus_we = 1; bus_addr = 8'h0C; bus_wdata = 32'h40; tick();
        bus_en = 0; bus_we = 0; irq_in[6] = 1'b0; tick();
        chk_rd(8'h04, 32'h40, "R12 edge beats clear write");
        wr(8'h0C, 32'h40);
        chk_rd(8'h04, 32'h0, "R10 clear after overlap");

        wr(8'h04, 32'hFFFF_FFFF);
        chk_rd(8'h04, 32'hFFFF_FFFE, "R3 pending write replaces");
        chk_lvl(0, EXT, "R6 full set folds");
        chk_rd(8'hC0, 32'd31, "R6 top extended id");

        tick(); tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule